// File: doc/BRIEF.md
# Guarded Indexed Halfword Load Unit

This block is the load stage of a processor data path. It carries out one predicated, register-indexed, signed 16-bit load. Each operation supplies a guard register value, a flag that says whether a guard is present, a base value, an index value and a destination register number. The unit adds base and index to form a byte address and fetches two bytes through a simple read port. It then orders the bytes by the endianness bit captured with the operation, sign-extends the halfword to the register width and returns a register write request exactly three cycles after issue. A new operation can be accepted in every cycle.

A false guard cancels the operation. No memory request is made and the result carries a deasserted write enable. A misaligned address raises no exception. The unit makes no memory request for it, writes a fixed fill pattern and flags the result as misaligned. Reset asserts asynchronously on an active-low pin and is released synchronously. It empties the pipeline, so no stale write appears after reset.

Top module: `hwld_unit`

## Requirements
- R1: When `mem_req` is high, `mem_addr` equals the 32-bit wrapping sum `iss_base + iss_index` of the operation issued one cycle earlier. An index of 0xFFFFFFFC therefore subtracts 4.
- R2: `mem_req` rises in the cycle after issue. The memory returns data one cycle after the request, with bits [7:0] of `mem_rdata` holding the byte at `mem_addr` and bits [15:8] holding the byte at `mem_addr+1`.
- R3: With `big_endian` = 0, the byte at the effective address is the low byte of the halfword and the byte at address+1 is the high byte.
- R4: With `big_endian` = 1, the byte at the effective address is the high byte. For example, bytes 0x22 at 0xD02 and 0x11 at 0xD03, loaded from base 0xD00 and index 2, give 0x00002211.
- R5: The halfword is sign-extended to 32 bits. Bytes 0x84 at 0xD00 and 0x33 at 0xD01, loaded big-endian from base 0xD04 and index 0xFFFFFFFC, give 0xFFFF8433.
- R6: For a guarded operation only bit 0 of `iss_guard` counts. If that bit is 0, no `mem_req` appears, and the result still arrives with `res_valid` = 1, `res_wen` = 0 and `res_misalign` = 0.
- R7: An operation with `iss_guarded` = 0 behaves as if its guard were true, whatever value `iss_guard` holds.
- R8: An enabled operation whose effective address is odd makes no `mem_req`. Its result has `res_wen` = 1, `res_misalign` = 1 and `res_data` equal to the parameter `FILL` (default 0xBAD0BAD0).
- R9: The result (`res_valid`, `res_wen`, `res_dest`, `res_data`, `res_misalign`) appears three cycles after issue, and operations issued in consecutive cycles produce results in consecutive cycles.
- R10: While `rst_n` is low, and until the first issue after its synchronised release, `res_valid`, `res_wen` and `mem_req` stay 0. Operations in flight when reset asserts produce no result.
- R11: The endianness used for an operation is the value of `big_endian` in its issue cycle. Later changes of `big_endian` do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| iss_valid | input | 1 | Operation issued this cycle |
| iss_guarded | input | 1 | Operation carries a guard |
| iss_guard | input | 32 | Guard register value; only bit 0 counts |
| iss_base | input | 32 | Base source value |
| iss_index | input | 32 | Index source value (two's complement) |
| iss_dest | input | 7 | Destination register number |
| big_endian | input | 1 | Byte order for operations issued this cycle |
| mem_req | output | 1 | Two-byte read request |
| mem_addr | output | 32 | Even byte address of the request |
| mem_rdata | input | 16 | Read data, one cycle after the request |
| res_valid | output | 1 | Result slot of an issued operation |
| res_wen | output | 1 | Destination write enable |
| res_dest | output | 7 | Destination register number |
| res_data | output | 32 | Value to write |
| res_misalign | output | 1 | Write carries the fill pattern because the address was odd |

## Verification
Each operation has two timed outcomes. The memory request, if any, is due one cycle after issue, and the result slot is due three cycles after issue. The bench drives inputs on the falling edge and keeps each operation's expectation in a small ring indexed by issue cycle. On every falling edge it compares the request outputs against the entry from one cycle back and the result outputs against the entry from three cycles back. Because it does this for back-to-back, idle-separated and reset-interrupted traffic, a result that arrives early, late or not at all shows up as a mismatch in that exact slot.

// File: rtl/hwld_pkg.sv
package hwld_pkg;

  // Per-operation control carried along the pipeline
  typedef struct packed {
    logic wen;   // guard passed (or no guard)
    logic mis;   // effective address odd
    logic be;    // byte order captured at issue
  } hwld_ctl_t;

  // Arrange the two fetched bytes into a halfword.
  // raw[7:0] is the byte at the address, raw[15:8] the byte at address+1.
  function automatic logic [15:0] hwld_order(input logic [15:0] raw, input logic be);
    logic [15:0] h;
    if (be) h = {raw[7:0], raw[15:8]};
    else    h = raw;
    return h;
  endfunction

endpackage

// File: rtl/hwld_rst_sync.sv
module hwld_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hwld_issue.sv
module hwld_issue
  import hwld_pkg::*;
#(
  parameter int XW = 32,
  parameter int RW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic          iss_guarded,
  input  logic [XW-1:0] iss_guard,
  input  logic [XW-1:0] iss_base,
  input  logic [XW-1:0] iss_index,
  input  logic [RW-1:0] iss_dest,
  input  logic          big_endian,
  output logic          s1_valid,
  output hwld_ctl_t     s1_ctl,
  output logic [RW-1:0] s1_dest,
  output logic          mem_req,
  output logic [XW-1:0] mem_addr
);
  // Only bit 0 of the guard is architecturally meaningful
  logic guard_hi_unused;
  assign guard_hi_unused = |iss_guard[XW-1:1];

  // Next-state
  logic [XW-1:0] addr_d;
  hwld_ctl_t     ctl_d;
  logic          load_en;

  always_comb begin
    addr_d     = iss_base + iss_index;
    ctl_d.wen  = !iss_guarded || iss_guard[0];
    ctl_d.mis  = addr_d[0];
    ctl_d.be   = big_endian;
    load_en    = iss_valid;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= iss_valid;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      s1_ctl   <= ctl_d;
      s1_dest  <= iss_dest;
      mem_addr <= addr_d;
    end
  end

  assign mem_req = s1_valid && s1_ctl.wen && !s1_ctl.mis;

  // R6
  req_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $past(iss_valid && (!iss_guarded || iss_guard[0])));
  // R1
  req_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr == $past(iss_base + iss_index)));
  // R8
  req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[0] == 1'b0));
endmodule

// File: rtl/hwld_hold.sv
module hwld_hold
  import hwld_pkg::*;
#(
  parameter int RW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s1_valid,
  input  hwld_ctl_t     s1_ctl,
  input  logic [RW-1:0] s1_dest,
  output logic          s2_valid,
  output hwld_ctl_t     s2_ctl,
  output logic [RW-1:0] s2_dest
);
  // Covers the memory read cycle; data arrives with s2
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_valid <= 1'b0;
    else        s2_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      s2_ctl  <= s1_ctl;
      s2_dest <= s1_dest;
    end
  end
endmodule

// File: rtl/hwld_format.sv
module hwld_format
  import hwld_pkg::*;
#(
  parameter int          XW   = 32,
  parameter int          RW   = 7,
  parameter logic [XW-1:0] FILL = 32'hBAD0_BAD0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s2_valid,
  input  hwld_ctl_t     s2_ctl,
  input  logic [RW-1:0] s2_dest,
  input  logic [15:0]   mem_rdata,
  output logic          res_valid,
  output logic          res_wen,
  output logic [RW-1:0] res_dest,
  output logic [XW-1:0] res_data,
  output logic          res_misalign
);
  localparam int EXT_W = XW - 16;

  logic [15:0]   half;
  logic [XW-1:0] ext;
  logic [XW-1:0] data_d;
  logic          wen_d;
  logic          mis_d;

  always_comb half = hwld_order(mem_rdata, s2_ctl.be);

  generate
    if (EXT_W > 0) begin : g_ext
      always_comb ext = {{EXT_W{half[15]}}, half};
    end else begin : g_noext
      always_comb ext = half[XW-1:0];
    end
  endgenerate

  always_comb begin
    wen_d  = s2_valid && s2_ctl.wen;
    mis_d  = wen_d && s2_ctl.mis;
    data_d = s2_ctl.mis ? FILL : ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_wen      <= 1'b0;
      res_misalign <= 1'b0;
    end else begin
      res_valid    <= s2_valid;
      res_wen      <= wen_d;
      res_misalign <= mis_d;
    end
  end

  always_ff @(posedge clk) begin
    if (s2_valid) res_dest <= s2_dest;
    if (wen_d)    res_data <= data_d;
  end

  // R6
  wen_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_wen |-> res_valid);
  // R8
  mis_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_misalign |-> (res_wen && res_data == FILL));
  // R5
  sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_wen && !res_misalign) |-> (res_data[XW-1:15] == {(EXT_W+1){res_data[15]}}));
endmodule

// File: rtl/hwld_unit.sv
module hwld_unit
  import hwld_pkg::*;
#(
  parameter int            XW   = 32,
  parameter int            RW   = 7,
  parameter logic [XW-1:0] FILL = 32'hBAD0_BAD0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic          iss_guarded,
  input  logic [XW-1:0] iss_guard,
  input  logic [XW-1:0] iss_base,
  input  logic [XW-1:0] iss_index,
  input  logic [RW-1:0] iss_dest,
  input  logic          big_endian,
  output logic          mem_req,
  output logic [XW-1:0] mem_addr,
  input  logic [15:0]   mem_rdata,
  output logic          res_valid,
  output logic          res_wen,
  output logic [RW-1:0] res_dest,
  output logic [XW-1:0] res_data,
  output logic          res_misalign
);
  logic          rst_n_s;
  logic          s1_valid, s2_valid;
  hwld_ctl_t     s1_ctl, s2_ctl;
  logic [RW-1:0] s1_dest, s2_dest;

  hwld_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  hwld_issue #(.XW(XW), .RW(RW)) u_issue (
    .clk(clk), .rst_n(rst_n_s),
    .iss_valid(iss_valid), .iss_guarded(iss_guarded), .iss_guard(iss_guard),
    .iss_base(iss_base), .iss_index(iss_index), .iss_dest(iss_dest),
    .big_endian(big_endian),
    .s1_valid(s1_valid), .s1_ctl(s1_ctl), .s1_dest(s1_dest),
    .mem_req(mem_req), .mem_addr(mem_addr)
  );

  hwld_hold #(.RW(RW)) u_hold (
    .clk(clk), .rst_n(rst_n_s),
    .s1_valid(s1_valid), .s1_ctl(s1_ctl), .s1_dest(s1_dest),
    .s2_valid(s2_valid), .s2_ctl(s2_ctl), .s2_dest(s2_dest)
  );

  hwld_format #(.XW(XW), .RW(RW), .FILL(FILL)) u_fmt (
    .clk(clk), .rst_n(rst_n_s),
    .s2_valid(s2_valid), .s2_ctl(s2_ctl), .s2_dest(s2_dest),
    .mem_rdata(mem_rdata),
    .res_valid(res_valid), .res_wen(res_wen), .res_dest(res_dest),
    .res_data(res_data), .res_misalign(res_misalign)
  );

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    res_valid |-> $past(iss_valid, 3));
  // R10
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!res_valid && !mem_req));
endmodule

// File: tb/sim_hwld_unit.sv
module sim_hwld_unit;
  localparam int          CLK_PERIOD = 10;
  localparam int          XW = 32;
  localparam int          RW = 7;
  localparam logic [31:0] FILL = 32'hBAD0_BAD0;
  localparam int          WATCHDOG = 20000;

  logic          clk;
  logic          rst_n;
  logic          iss_valid, iss_guarded, big_endian;
  logic [31:0]   iss_guard, iss_base, iss_index;
  logic [RW-1:0] iss_dest;
  logic          mem_req;
  logic [31:0]   mem_addr;
  logic [15:0]   mem_rdata;
  logic          res_valid, res_wen, res_misalign;
  logic [RW-1:0] res_dest;
  logic [31:0]   res_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  hwld_unit #(.XW(XW), .RW(RW), .FILL(FILL)) u0 (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_guarded(iss_guarded), .iss_guard(iss_guard),
    .iss_base(iss_base), .iss_index(iss_index), .iss_dest(iss_dest),
    .big_endian(big_endian),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .res_valid(res_valid), .res_wen(res_wen), .res_dest(res_dest),
    .res_data(res_data), .res_misalign(res_misalign)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Computed memory contents with a few directed bytes
  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    case (a)
      32'h0000_0D00: return 8'h84;
      32'h0000_0D01: return 8'h33;
      32'h0000_0D02: return 8'h22;
      32'h0000_0D03: return 8'h11;
      default:       return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h5A ^ {a[2:0], 5'b0};
    endcase
  endfunction

  // Memory model: one cycle read latency (R2)
  always @(posedge clk) begin
    if (mem_req) mem_rdata <= {mem_byte(mem_addr + 32'd1), mem_byte(mem_addr)};
  end

  function automatic logic [31:0] exp_load(input logic [31:0] a, input logic be);
    logic [7:0]  b0, b1;
    logic [15:0] h;
    b0 = mem_byte(a);
    b1 = mem_byte(a + 32'd1);
    h  = be ? {b0, b1} : {b1, b0};
    return {{16{h[15]}}, h};
  endfunction

  // Expectation ring indexed by issue cycle
  logic          sv[8], swen[8], smis[8], sreq[8], sbe[8], sgd[8];
  logic [31:0]   sdata[8], saddr[8];
  logic [RW-1:0] sdest[8];
  int t;

  task automatic clear_slots();
    for (int i = 0; i < 8; i++) begin
      sv[i] = 0; swen[i] = 0; smis[i] = 0; sreq[i] = 0; sbe[i] = 0; sgd[i] = 0;
      sdata[i] = '0; saddr[i] = '0; sdest[i] = '0;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (t=%0d)", tag, act, exp, t);
    end
  endtask

  task automatic drive_idle();
    iss_valid = 0; iss_guarded = 0; iss_guard = '0; iss_base = '0;
    iss_index = '0; iss_dest = '0; big_endian = 0;
  endtask

  // One cycle: check due outputs, then issue (or idle)
  task automatic cyc(input logic v, input logic gd, input logic [31:0] g,
                     input logic [31:0] b, input logic [31:0] x,
                     input logic [RW-1:0] d, input logic be);
    int r, m, s;
    logic [31:0] a;
    logic en;
    @(negedge clk);
    m = (t - 1) & 7;
    r = (t - 3) & 7;
    // Request due one cycle after issue (R1, R2, R6, R8)
    chk("R2 mem_req", {31'b0, mem_req}, {31'b0, sreq[m]});
    if (sreq[m]) chk("R1 mem_addr", mem_addr, saddr[m]);
    // Result due three cycles after issue (R9)
    chk("R9 res_valid", {31'b0, res_valid}, {31'b0, sv[r]});
    if (sv[r]) begin
      chk(sgd[r] ? "R6 res_wen" : "R7 res_wen", {31'b0, res_wen}, {31'b0, swen[r]});
      chk("R8 res_misalign", {31'b0, res_misalign}, {31'b0, smis[r]});
      chk("R9 res_dest", {25'b0, res_dest}, {25'b0, sdest[r]});
      if (swen[r]) begin
        if (smis[r])     chk("R8 fill", res_data, sdata[r]);
        else if (sbe[r]) chk("R4 R5 R11 data", res_data, sdata[r]);
        else             chk("R3 R5 R11 data", res_data, sdata[r]);
      end
    end
    // Issue
    s  = t & 7;
    a  = b + x;
    en = v && (!gd || g[0]);
    sv[s] = v; swen[s] = en; smis[s] = en && a[0]; sreq[s] = en && !a[0];
    sbe[s] = be; sgd[s] = gd; saddr[s] = a; sdest[s] = d;
    sdata[s] = a[0] ? FILL : exp_load(a, be);
    iss_valid = v; iss_guarded = gd; iss_guard = g; iss_base = b;
    iss_index = x; iss_dest = d; big_endian = be;
    t++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] b, x;
    void'($urandom(32'h0BAD_5EED));
    drive_idle();
    clear_slots();
    t = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset res_valid", {31'b0, res_valid}, 32'd0);
    chk("R10 reset mem_req", {31'b0, mem_req}, 32'd0);
    rst_n = 1;
    idle(4);

    // Directed: big-endian examples and their little-endian twins (R4, R5, R3)
    cyc(1, 0, 32'h0, 32'h0000_0D00, 32'h2,         7'd80, 1);  // 0x00002211
    cyc(1, 1, 32'h0, 32'h0000_0D04, 32'hFFFF_FFFC, 7'd90, 1);  // guard false
    cyc(1, 1, 32'h1, 32'h0000_0D04, 32'hFFFF_FFFC, 7'd100, 1); // 0xFFFF8433
    cyc(1, 0, 32'h0, 32'h0000_0D01, 32'hFFFF_FFFC, 7'd110, 0); // misaligned
    cyc(1, 0, 32'h0, 32'h0000_0D00, 32'h2,         7'd81, 0);  // 0x00001122
    cyc(1, 1, 32'hFFFF_FFFE, 32'h0000_0D04, 32'hFFFF_FFFC, 7'd91, 0); // R6 upper bits ignored
    cyc(1, 0, 32'hFFFF_FFFE, 32'h0000_0D04, 32'hFFFF_FFFC, 7'd92, 0); // R7 unguarded
    cyc(1, 1, 32'h3, 32'hFFFF_FFFF, 32'h1, 7'd5, 1);           // wrap to 0
    cyc(1, 1, 32'h1, 32'h7FFF_FFFF, 32'h0, 7'd6, 1);           // guarded misaligned
    idle(4);
    if (1) begin
      // Explicit value checks on the directed examples
      chk("R4 example value", exp_load(32'hD02, 1), 32'h0000_2211);
      chk("R5 example value", exp_load(32'hD00, 1), 32'hFFFF_8433);
    end

    // Constrained random traffic
    for (int i = 0; i < 600; i++) begin
      b = $urandom;
      x = $urandom;
      if (($urandom % 8) != 0) x[0] = b[0];
      cyc(($urandom % 10) < 8, $urandom % 2, $urandom, b, x,
          RW'($urandom), $urandom % 2);
    end
    idle(4);

    // R10: reset with operations in flight
    cyc(1, 0, 0, 32'h100, 32'h2, 7'd1, 0);
    cyc(1, 0, 0, 32'h200, 32'h4, 7'd2, 1);
    #1 rst_n = 0;
    @(negedge clk);
    chk("R10 flush res_valid", {31'b0, res_valid}, 32'd0);
    chk("R10 flush mem_req", {31'b0, mem_req}, 32'd0);
    iss_valid = 1;
    @(negedge clk);
    chk("R10 held res_valid", {31'b0, res_valid}, 32'd0);
    chk("R10 held res_wen", {31'b0, res_wen}, 32'd0);
    drive_idle();
    rst_n = 1;
    clear_slots();
    t = 0;
    idle(5);
    cyc(1, 0, 0, 32'h0000_0D00, 32'h2, 7'd3, 1);
    idle(4);
    finish_run();
  end
endmodule